// File: doc/BRIEF.md
# Latched Bus Transceiver

This block connects two parallel buses, side A and side B, and moves data between them in either direction. The bus is split into equal lanes (two 8-bit lanes by default). Every lane has one storage element per direction. Data taken from one side is held there and put onto the other side through tri-state drivers. Each direction of each lane has three active-low controls:
- a direction enable, which gates both capture and driving;
- a latch enable, which chooses between following the input and holding;
- an output enable.

The storage is built as a register that samples the source bus on every clock edge while the latch is open. This is a clocked version of a transparent latch: a stored value appears on the far side one clock after it is sampled. Closing the latch keeps the last sampled value. An elaboration-time option, `GANGED`, makes the lane-0 controls govern every lane, so the block behaves as one wide transceiver. With this option set, the control inputs of the other lanes are ignored. Software must never enable both directions of one lane to drive at the same time.

Top module: `latched_xcvr`

## Requirements
- R1: After reset, with every control input high, the block drives no bit of either bus.
- R2: While a lane's A-to-B direction enable and latch enable are both low, its forward store takes the A-lane value at each clock edge. With the A-to-B output enable also low, that value is on the B lane one clock later.
- R3: After the A-to-B latch enable goes high, the forward store keeps the value sampled at the last edge while it was low, even if the A lane changes.
- R4: While the A-to-B direction enable is high, the forward store keeps its contents even if the latch enable is low.
- R5: A B lane is driven only while both its A-to-B direction enable and its A-to-B output enable are low. When driven, it carries the forward store contents. Otherwise the block releases that lane.
- R6: The B-to-A direction behaves as in R2 to R5, using its own three controls: it samples the B lane and drives the A lane.
- R7: The controls of one lane do not change the stored value or the driving state of any other lane.
- R8: Within a lane, the reverse controls and reverse traffic do not change the forward store, and the forward controls do not change the reverse store.
- R9: With `GANGED` = 1, the lane-0 controls apply to every lane. The control inputs of lanes 1 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the stores |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stores |
| a_io | inout | LANE_W*LANES | Side A bus; sampled by the forward stores, driven by the reverse stores |
| b_io | inout | LANE_W*LANES | Side B bus; sampled by the reverse stores, driven by the forward stores |
| a2b_dir_n | input | LANES | Per-lane A-to-B direction enable, active low |
| a2b_latch_n | input | LANES | Per-lane A-to-B latch enable, low = follow, high = hold |
| a2b_oe_n | input | LANES | Per-lane B-side output enable, active low |
| b2a_dir_n | input | LANES | Per-lane B-to-A direction enable, active low |
| b2a_latch_n | input | LANES | Per-lane B-to-A latch enable, low = follow, high = hold |
| b2a_oe_n | input | LANES | Per-lane A-side output enable, active low |

## Verification
The bench uses two instances, each with two 4-bit lanes. The first is separate-lane (`GANGED` = 0) and the second is ganged (`GANGED` = 1). The narrow lanes make it practical to push all sixteen codes through each lane in both directions, and to check that each code is held after the latch closes. The two-lane layout allows one lane to hold while the other follows, and allows the ganged copy to receive conflicting lane-1 controls so that R9 can be observed at the B bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Control set of one direction of one lane; all fields active low.
    typedef struct packed {
        logic dir_n;
        logic latch_n;
        logic oe_n;
    } dir_ctrl_t;

endpackage

// File: rtl/xcvr_ctrl_map.sv
module xcvr_ctrl_map
    import xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int GANGED = 0
) (
    input  logic [LANES-1:0]       dir_n,
    input  logic [LANES-1:0]       latch_n,
    input  logic [LANES-1:0]       oe_n,
    output dir_ctrl_t [LANES-1:0]  ctrl
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // In ganged mode every lane takes lane 0's control set.
        localparam int SRC = (GANGED != 0) ? 0 : l;
        assign ctrl[l].dir_n   = dir_n[SRC];
        assign ctrl[l].latch_n = latch_n[SRC];
        assign ctrl[l].oe_n    = oe_n[SRC];
    end

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] store,
    output logic         drive
);

    typedef struct packed {
        logic [W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ctrl.dir_n && !ctrl.latch_n) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign store = st_q.data;
    assign drive = ~ctrl.dir_n & ~ctrl.oe_n;

    // R2: an open latch with the direction enabled takes the input
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.dir_n && !ctrl.latch_n) |=> (store == $past(din)));

    // R3: a closed latch keeps its value
    p_closed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.latch_n |=> $stable(store));

    // R4: a disabled direction blocks capture
    p_dir_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.dir_n |=> $stable(store));

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int GANGED = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    inout  wire  [LANE_W*LANES-1:0]   a_io,
    inout  wire  [LANE_W*LANES-1:0]   b_io,
    input  logic [LANES-1:0]          a2b_dir_n,
    input  logic [LANES-1:0]          a2b_latch_n,
    input  logic [LANES-1:0]          a2b_oe_n,
    input  logic [LANES-1:0]          b2a_dir_n,
    input  logic [LANES-1:0]          b2a_latch_n,
    input  logic [LANES-1:0]          b2a_oe_n
);

    localparam int BUS_W = LANE_W * LANES;

    dir_ctrl_t [LANES-1:0] fwd_ctrl;
    dir_ctrl_t [LANES-1:0] rev_ctrl;
    logic [LANE_W-1:0]     fwd_q [LANES];
    logic [LANE_W-1:0]     rev_q [LANES];
    logic [LANES-1:0]      fwd_drv;
    logic [LANES-1:0]      rev_drv;

    xcvr_ctrl_map #(.LANES(LANES), .GANGED(GANGED)) u_fwd_map (
        .dir_n   (a2b_dir_n),
        .latch_n (a2b_latch_n),
        .oe_n    (a2b_oe_n),
        .ctrl    (fwd_ctrl)
    );

    xcvr_ctrl_map #(.LANES(LANES), .GANGED(GANGED)) u_rev_map (
        .dir_n   (b2a_dir_n),
        .latch_n (b2a_latch_n),
        .oe_n    (b2a_oe_n),
        .ctrl    (rev_ctrl)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO = l * LANE_W;

        xcvr_store #(.W(LANE_W)) u_fwd (
            .clk   (clk),
            .rst_n (rst_n),
            .ctrl  (fwd_ctrl[l]),
            .din   (a_io[LO +: LANE_W]),
            .store (fwd_q[l]),
            .drive (fwd_drv[l])
        );

        xcvr_store #(.W(LANE_W)) u_rev (
            .clk   (clk),
            .rst_n (rst_n),
            .ctrl  (rev_ctrl[l]),
            .din   (b_io[LO +: LANE_W]),
            .store (rev_q[l]),
            .drive (rev_drv[l])
        );

        assign b_io[LO +: LANE_W] = fwd_drv[l] ? fwd_q[l] : {LANE_W{1'bz}};
        assign a_io[LO +: LANE_W] = rev_drv[l] ? rev_q[l] : {LANE_W{1'bz}};

        // R5: a driven B lane carries the forward store
        p_b_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_drv[l] |-> (b_io[LO +: LANE_W] == fwd_q[l]));

        // R6: a driven A lane carries the reverse store
        p_a_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rev_drv[l] |-> (a_io[LO +: LANE_W] == rev_q[l]));

        // R5: the two directions of a lane never drive together
        p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(fwd_drv[l] && rev_drv[l]));
    end

    if (GANGED != 0) begin : g_gang_chk
        // R9: every lane follows lane 0 when ganged
        p_gang_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (fwd_drv == {LANES{fwd_drv[0]}}) && (rev_drv == {LANES{rev_drv[0]}}));
    end

    initial begin
        assert (BUS_W > 0) else $error("bus width must be positive");
    end

endmodule

// File: tb/latched_xcvr_tb_top.sv
module latched_xcvr_tb_top;

    localparam int LW = 4;
    localparam int NL = 2;
    localparam int BW = LW * NL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 1'b0;

    // separate-lane instance
    wire  [BW-1:0] a_bus, b_bus;
    logic [NL-1:0] a_en = '0, b_en = '0;
    logic [BW-1:0] a_val = '0, b_val = '0;
    logic [NL-1:0] f_dir = '1, f_lat = '1, f_oe = '1;
    logic [NL-1:0] r_dir = '1, r_lat = '1, r_oe = '1;

    // ganged instance
    wire  [BW-1:0] ga_bus, gb_bus;
    logic [BW-1:0] ga_val = '0;
    logic [NL-1:0] g_dir = '1, g_lat = '1, g_oe = '1;
    logic [NL-1:0] g_one = '1;

    for (genvar l = 0; l < NL; l++) begin : g_drv
        assign a_bus[l*LW +: LW] = a_en[l] ? a_val[l*LW +: LW] : {LW{1'bz}};
        assign b_bus[l*LW +: LW] = b_en[l] ? b_val[l*LW +: LW] : {LW{1'bz}};
    end
    assign ga_bus = ga_val;

    latched_xcvr #(.LANE_W(LW), .LANES(NL), .GANGED(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_io(a_bus), .b_io(b_bus),
        .a2b_dir_n(f_dir), .a2b_latch_n(f_lat), .a2b_oe_n(f_oe),
        .b2a_dir_n(r_dir), .b2a_latch_n(r_lat), .b2a_oe_n(r_oe)
    );

    latched_xcvr #(.LANE_W(LW), .LANES(NL), .GANGED(1)) gang_i (
        .clk(clk), .rst_n(rst_n), .a_io(ga_bus), .b_io(gb_bus),
        .a2b_dir_n(g_dir), .a2b_latch_n(g_lat), .a2b_oe_n(g_oe),
        .b2a_dir_n(g_one), .b2a_latch_n(g_one), .b2a_oe_n(g_one)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk_eq(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // released lane: no bit may be driven high (stored data is non-zero)
    task automatic chk_rel(string req, logic [LW-1:0] act);
        bit bad = 1'b0;
        for (int i = 0; i < LW; i++) if (act[i] === 1'b1) bad = 1'b1;
        checks++;
        if (bad) begin
            errs++;
            $display("FAIL %s: actual=%b expected=released", req, act);
        end
    endtask

    function automatic logic [LW-1:0] lane(logic [BW-1:0] bus, int l);
        return bus[l*LW +: LW];
    endfunction

    task automatic fwd(int l, logic d, logic le, logic oe);
        f_dir[l] = d; f_lat[l] = le; f_oe[l] = oe;
    endtask

    task automatic rev(int l, logic d, logic le, logic oe);
        r_dir[l] = d; r_lat[l] = le; r_oe[l] = oe;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        tick();

        // R1: idle after reset
        for (int l = 0; l < NL; l++) begin
            chk_rel("R1 a idle", lane(a_bus, l));
            chk_rel("R1 b idle", lane(b_bus, l));
            chk_rel("R1 ganged b idle", lane(gb_bus, l));
        end

        // R2 / R3: forward sweep of every code per lane
        a_en = '1;
        for (int l = 0; l < NL; l++) begin
            for (int v = 0; v < (1 << LW); v++) begin
                a_val[l*LW +: LW] = LW'(v);
                fwd(l, 1'b0, 1'b0, 1'b0);
                tick();
                chk_eq("R2 forward follow", lane(b_bus, l), LW'(v));
                fwd(l, 1'b0, 1'b1, 1'b0);
                a_val[l*LW +: LW] = LW'(~v);
                tick();
                chk_eq("R3 forward hold", lane(b_bus, l), LW'(v));
            end
        end

        // R4 / R5 on lane 0
        a_val[0 +: LW] = 4'hA;
        fwd(0, 1'b0, 1'b0, 1'b0);
        tick();
        fwd(0, 1'b1, 1'b0, 1'b0);
        a_val[0 +: LW] = 4'h5;
        tick();
        chk_rel("R5 dir high releases b", lane(b_bus, 0));
        tick();
        fwd(0, 1'b0, 1'b1, 1'b0);
        tick();
        chk_eq("R4 dir high blocks capture", lane(b_bus, 0), 4'hA);
        fwd(0, 1'b0, 1'b1, 1'b1);
        tick();
        chk_rel("R5 oe high releases b", lane(b_bus, 0));
        fwd(0, 1'b0, 1'b1, 1'b0);
        tick();
        chk_eq("R5 oe low drives store", lane(b_bus, 0), 4'hA);

        // R7: lane 0 holds 3 while lane 1 follows
        a_val[0 +: LW] = 4'h3;
        fwd(0, 1'b0, 1'b0, 1'b0);
        tick();
        fwd(0, 1'b0, 1'b1, 1'b0);
        fwd(1, 1'b0, 1'b0, 1'b0);
        for (int v = 0; v < (1 << LW); v++) begin
            a_val = {LW'(v), LW'(~v)};
            tick();
            chk_eq("R7 held lane unaffected", lane(b_bus, 0), 4'h3);
            chk_eq("R7 open lane follows", lane(b_bus, 1), LW'(v));
        end
        fwd(1, 1'b1, 1'b1, 1'b1);
        tick();
        chk_eq("R7 lane1 release keeps lane0", lane(b_bus, 0), 4'h3);
        chk_rel("R7 lane1 released", lane(b_bus, 1));

        // R6: reverse sweep; forward side quiet but lane stores kept
        for (int l = 0; l < NL; l++) fwd(l, 1'b0, 1'b1, 1'b1);
        a_en = '0;
        tick();
        b_en = '1;
        for (int l = 0; l < NL; l++) begin
            for (int v = 0; v < (1 << LW); v++) begin
                b_val[l*LW +: LW] = LW'(v);
                rev(l, 1'b0, 1'b0, 1'b0);
                tick();
                chk_eq("R6 reverse follow", lane(a_bus, l), LW'(v));
                rev(l, 1'b0, 1'b1, 1'b0);
                b_val[l*LW +: LW] = LW'(~v);
                tick();
                chk_eq("R6 reverse hold", lane(a_bus, l), LW'(v));
            end
            rev(l, 1'b1, 1'b1, 1'b1);
        end

        // R8: forward store of lane 0 (3) survived reverse traffic
        b_en = '0;
        tick();
        fwd(0, 1'b0, 1'b1, 1'b0);
        tick();
        chk_eq("R8 forward kept across reverse", lane(b_bus, 0), 4'h3);
        chk_rel("R8 reverse quiet on a", lane(a_bus, 0));

        // R9: ganged instance, lane 0 controls rule all lanes
        g_dir = 2'b10; g_lat = 2'b10; g_oe = 2'b10;
        for (int v = 0; v < (1 << LW); v++) begin
            ga_val = {LW'(~v), LW'(v)};
            tick();
            chk_eq("R9 ganged lane0", lane(gb_bus, 0), LW'(v));
            chk_eq("R9 ganged lane1 follows lane0 ctrl", lane(gb_bus, 1), LW'(~v));
        end
        ga_val = {4'h6, 4'h9};
        tick();
        g_dir = 2'b01; g_lat = 2'b01; g_oe = 2'b01;
        ga_val = 8'h00;
        tick();
        chk_rel("R9 ganged lane0 released", lane(gb_bus, 0));
        chk_rel("R9 lane1 ctrl ignored", lane(gb_bus, 1));
        g_dir = 2'b00; g_lat = 2'b11; g_oe = 2'b00;
        tick();
        chk_eq("R9 ganged hold lane0", lane(gb_bus, 0), 4'h9);
        chk_eq("R9 ganged hold lane1", lane(gb_bus, 1), 4'h6);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog all: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule